// File: doc/BRIEF.md
# Receive FIFO Status and Event Register

This block holds the receive queue of one serial channel, together with the status word that software reads for that channel. Every received character goes into a 16-entry queue with four tags: break, framing error, parity error and overrun. The status word shows the tags of the entry at the head of the queue. Popping the queue, which is the side effect of reading the receive data register, moves the next entry's tags into view. An active-low bit reports whether the queue is empty.

The same word holds four sticky event flags: reception error, receive timeout, transmit space request and receive data request. Software clears a flag by writing 0 to it, and a write of 1 leaves the flag alone. The two request flags compare against trigger levels that software programs. A masked OR of the four flags drives one interrupt line. The line shifter, the baud generator and any DMA engine sit outside this block.

Top module: `uart_rx_status`

## Requirements
- R1: After reset, `status_o` reads 0x0000_4100. The empty bit (14) and the transmit request flag (8) are 1, and every other bit is 0.
- R2: Bit 14 is active low. It reads 0 while the receive queue holds at least one entry and 1 when the queue is empty.
- R3: Bits 15, 13, 12 and 11 show the head entry's tags: break, framing, parity and overrun. `rx_data_o` shows the head entry's data byte. A pop advances both to the next entry. The tag bits read 0 when the queue is empty.
- R4: The queue holds 16 entries. A push while the queue is full is dropped, and the newest stored entry then gets its overrun tag set. A pop while the queue is empty has no effect.
- R5: Bit 10, the reception error flag, sets on the clock edge of any push that carries a framing, parity or overrun tag. It also sets on the clock edge of a dropped push.
- R6: Bit 9, the timeout flag, sets on the clock edge that samples `timeout_i` high.
- R7: Bit 8, the transmit request flag, sets on any edge where `tx_free_i` is at least the effective transmit trigger level. A trigger level of 0 counts as 1.
- R8: Bit 7, the receive request flag, sets on any edge where the queue holds at least the effective receive trigger level of entries. A trigger level of 0 counts as 1.
- R9: Bits 10 to 7 are cleared by writing 0. A write to one of these bits with `status_wr_i` high and a data bit of 0 clears that flag, and a data bit of 1 leaves it unchanged. If a set condition and a clear fall on the same edge, the set wins.
- R10: `irq_o` is the OR of the four flags, each ANDed with its bit of `irq_en_i`. The order is [3] = bit 10, [2] = bit 9, [1] = bit 8, [0] = bit 7.
- R11: Bits 31 to 16 and bits 6 to 0 of `status_o` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_push_i | input | 1 | Write one received character into the queue |
| rx_data_i | input | 8 | Received data byte |
| rx_brk_i | input | 1 | Break tag of the pushed character |
| rx_fer_i | input | 1 | Framing error tag |
| rx_per_i | input | 1 | Parity error tag |
| rx_oer_i | input | 1 | Overrun tag from the receiver |
| rx_pop_i | input | 1 | Remove the head entry (data register read) |
| rx_data_o | output | 8 | Data byte of the head entry |
| timeout_i | input | 1 | Receive timeout event pulse |
| tx_free_i | input | 5 | Free entries in the transmit FIFO |
| tx_trig_i | input | 4 | Transmit trigger level |
| rx_trig_i | input | 4 | Receive trigger level |
| status_wr_i | input | 1 | Write strobe for the status word |
| status_wdata_i | input | 32 | Write data; a 0 in bits 10 to 7 clears that flag |
| status_o | output | 32 | Status word |
| irq_en_i | input | 4 | Per-flag interrupt enables |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a depth of 16, 8-bit data and 4-bit trigger levels. With these values, sixteen pushes fill the queue and a seventeenth push is dropped, so the overrun tag can be checked on the last stored entry. A trigger level of 15 can be tested at the edge between 14 and 15 stored entries. The trigger level of 0 can be shown to behave like 1, and a clear can be written while a level condition is still true, to show that the set wins.

// File: rtl/uart_rx_stat_pkg.sv
package uart_rx_stat_pkg;
  typedef struct packed {
    logic brk;
    logic fer;
    logic per;
    logic oer;
  } rx_tag_t;

  localparam int unsigned EVT_W = 4;
  // flag index order, also the irq_en order
  localparam int unsigned EVT_RDR = 0;
  localparam int unsigned EVT_TDR = 1;
  localparam int unsigned EVT_TMO = 2;
  localparam int unsigned EVT_ERR = 3;
endpackage

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
  import uart_rx_stat_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  rx_tag_t           tag_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_data_o,
  output rx_tag_t           head_tag_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              drop_o
);
  typedef struct packed {
    rx_tag_t           tag;
    logic [DATA_W-1:0] data;
  } entry_t;

  entry_t            mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              full, empty, do_push, do_pop;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && !empty;
  assign drop_o  = push_i && full;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= '{tag: tag_i, data: data_i};
    // overflow marks the newest stored entry
    else if (drop_o) mem_q[wr_ptr_q - PTR_W'(1)].tag.oer <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + PTR_W'(1);
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + PTR_W'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_data_o = empty ? '0 : mem_q[rd_ptr_q].data;
  assign head_tag_o  = empty ? '0 : mem_q[rd_ptr_q].tag;
  assign count_o     = cnt_q;
endmodule

// File: rtl/evt_flags.sv
module evt_flags
  import uart_rx_stat_pkg::*;
#(
  parameter int unsigned CNT_W  = 5,
  parameter int unsigned TRIG_W = 4,
  localparam int unsigned CMP_W = CNT_W + TRIG_W,
  localparam logic [EVT_W-1:0] RST_VAL = EVT_W'(1) << EVT_TDR
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              err_evt_i,
  input  logic              tmo_i,
  input  logic [CNT_W-1:0]  tx_free_i,
  input  logic [TRIG_W-1:0] tx_trig_i,
  input  logic [CNT_W-1:0]  rx_cnt_i,
  input  logic [TRIG_W-1:0] rx_trig_i,
  input  logic              wr_i,
  input  logic [EVT_W-1:0]  wr_bits_i,
  output logic [EVT_W-1:0]  flags_o
);
  function automatic logic [CMP_W-1:0] eff_lvl(input logic [TRIG_W-1:0] lvl);
    return (lvl == '0) ? CMP_W'(1) : CMP_W'(lvl);
  endfunction

  logic [EVT_W-1:0] set_v, clr_v, flags_q;

  always_comb begin
    set_v          = '0;
    set_v[EVT_ERR] = err_evt_i;
    set_v[EVT_TMO] = tmo_i;
    set_v[EVT_TDR] = CMP_W'(tx_free_i) >= eff_lvl(tx_trig_i);
    set_v[EVT_RDR] = CMP_W'(rx_cnt_i) >= eff_lvl(rx_trig_i);
  end

  assign clr_v = wr_i ? ~wr_bits_i : '0;

  for (genvar i = 0; i < EVT_W; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flags_q[i] <= RST_VAL[i];
      else if (set_v[i]) flags_q[i] <= 1'b1;  // set beats clear
      else if (clr_v[i]) flags_q[i] <= 1'b0;
    end
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_stat_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned TRIG_W = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_push_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_brk_i,
  input  logic              rx_fer_i,
  input  logic              rx_per_i,
  input  logic              rx_oer_i,
  input  logic              rx_pop_i,
  output logic [DATA_W-1:0] rx_data_o,
  input  logic              timeout_i,
  input  logic [CNT_W-1:0]  tx_free_i,
  input  logic [TRIG_W-1:0] tx_trig_i,
  input  logic [TRIG_W-1:0] rx_trig_i,
  input  logic              status_wr_i,
  input  logic [31:0]       status_wdata_i,
  output logic [31:0]       status_o,
  input  logic [EVT_W-1:0]  irq_en_i,
  output logic              irq_o
);
  rx_tag_t          in_tag, head_tag;
  logic [CNT_W-1:0] rx_cnt;
  logic             drop, err_evt;
  logic [EVT_W-1:0] flags;

  assign in_tag = '{brk: rx_brk_i, fer: rx_fer_i, per: rx_per_i, oer: rx_oer_i};

  rx_tag_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_fifo (
    .clk_i, .rst_ni,
    .push_i      (rx_push_i),
    .data_i      (rx_data_i),
    .tag_i       (in_tag),
    .pop_i       (rx_pop_i),
    .head_data_o (rx_data_o),
    .head_tag_o  (head_tag),
    .count_o     (rx_cnt),
    .drop_o      (drop)
  );

  assign err_evt = (rx_push_i && (rx_fer_i || rx_per_i || rx_oer_i)) || drop;

  evt_flags #(.CNT_W(CNT_W), .TRIG_W(TRIG_W)) i_flags (
    .clk_i, .rst_ni,
    .err_evt_i (err_evt),
    .tmo_i     (timeout_i),
    .tx_free_i,
    .tx_trig_i,
    .rx_cnt_i  (rx_cnt),
    .rx_trig_i,
    .wr_i      (status_wr_i),
    .wr_bits_i (status_wdata_i[10:7]),
    .flags_o   (flags)
  );

  // status_wdata_i bits outside 10:7 have no storage
  always_comb begin
    status_o       = '0;
    status_o[15]   = head_tag.brk;
    status_o[14]   = (rx_cnt == '0);
    status_o[13]   = head_tag.fer;
    status_o[12]   = head_tag.per;
    status_o[11]   = head_tag.oer;
    status_o[10:7] = flags;
  end

  assign irq_o = |(flags & irq_en_i);
endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rx_push_i,
  input logic        rx_fer_i,
  input logic        rx_per_i,
  input logic        rx_oer_i,
  input logic        rx_pop_i,
  input logic        timeout_i,
  input logic        status_wr_i,
  input logic        tmo_wbit_i,
  input logic [31:0] status_o,
  input logic [3:0]  irq_en_i,
  input logic        irq_o
);
  // R2
  empty_after_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[14]) |-> $past(rx_pop_i));

  // R5
  err_flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_i && (rx_fer_i || rx_per_i || rx_oer_i) |=> status_o[10]);

  // R6
  tmo_flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_i |=> status_o[9]);

  // R9
  tmo_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_wr_i && !tmo_wbit_i && !timeout_i |=> !status_o[9]);

  // R10
  irq_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i == 4'b0) |-> !irq_o);

  // R11
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o & 32'hFFFF_007F) == 32'h0);
endmodule

bind uart_rx_status uart_rx_status_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_push_i   (rx_push_i),
  .rx_fer_i    (rx_fer_i),
  .rx_per_i    (rx_per_i),
  .rx_oer_i    (rx_oer_i),
  .rx_pop_i    (rx_pop_i),
  .timeout_i   (timeout_i),
  .status_wr_i (status_wr_i),
  .tmo_wbit_i  (status_wdata_i[9]),
  .status_o    (status_o),
  .irq_en_i    (irq_en_i),
  .irq_o       (irq_o)
);

// File: tb/test_uart_rx_status.sv
module test_uart_rx_status;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rx_push_i = 0, rx_brk_i = 0, rx_fer_i = 0, rx_per_i = 0, rx_oer_i = 0;
  logic [7:0]  rx_data_i = '0;
  logic        rx_pop_i = 0, timeout_i = 0, status_wr_i = 0;
  logic [4:0]  tx_free_i = '0;
  logic [3:0]  tx_trig_i = 4'd15, rx_trig_i = 4'd15, irq_en_i = '0;
  logic [31:0] status_wdata_i = '0;
  logic [7:0]  rx_data_o;
  logic [31:0] status_o;
  logic        irq_o;
  int n_run = 0, n_fail = 0;

  always #10 clk_i = ~clk_i;

  uart_rx_status i_uart_rx_status (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic [3:0] t);
    @(negedge clk_i);
    rx_push_i = 1; rx_data_i = d;
    {rx_brk_i, rx_fer_i, rx_per_i, rx_oer_i} = t;
    @(negedge clk_i);
    rx_push_i = 0; {rx_brk_i, rx_fer_i, rx_per_i, rx_oer_i} = '0;
  endtask

  task automatic pop();
    @(negedge clk_i); rx_pop_i = 1;
    @(negedge clk_i); rx_pop_i = 0;
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk_i); status_wr_i = 1; status_wdata_i = d;
    @(negedge clk_i); status_wr_i = 0; status_wdata_i = '0;
  endtask

  task automatic t_reset();
    chk("R1 reset status", status_o, 32'h0000_4100);
    chk("R11 reserved", status_o & 32'hFFFF_007F, 0);
  endtask

  task automatic t_w0c();
    wr(32'h0);
    chk("R9 clear all", status_o, 32'h0000_4000);
    @(negedge clk_i); timeout_i = 1;
    @(negedge clk_i); timeout_i = 0;
    chk("R6 timeout set", status_o[9], 1);
    wr(32'h0000_0200);
    chk("R9 write 1 keeps", status_o[9], 1);
    wr(32'hFFFF_FDFF);
    chk("R9 write 0 clears", status_o[9], 0);
  endtask

  task automatic t_tags();
    push(8'hA5, 4'b1000);
    chk("R2 not empty", status_o[14], 0);
    chk("R3 head brk", {status_o[15], status_o[13:11]}, 4'b1000);
    chk("R3 head data", rx_data_o, 8'hA5);
    chk("R5 no error on brk", status_o[10], 0);
    push(8'h3C, 4'b0100);
    chk("R5 frame err flag", status_o[10], 1);
    push(8'h11, 4'b0010);
    pop();
    chk("R3 fer tag after pop", {status_o[15], status_o[13:11]}, 4'b0100);
    chk("R3 data after pop", rx_data_o, 8'h3C);
    pop();
    chk("R3 per tag", {status_o[15], status_o[13:11]}, 4'b0010);
    pop();
    chk("R2 empty again", status_o[14], 1);
    chk("R3 tags zero empty", {status_o[15], status_o[13:11]}, 0);
    pop();
    chk("R4 pop empty ignored", status_o[14], 1);
    push(8'h77, 4'b0000);
    chk("R4 ptr intact after empty pop", rx_data_o, 8'h77);
    pop();
    wr(32'h0);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 14; i++) push(8'h40 + 8'(i), 4'b0000);
    @(negedge clk_i);
    chk("R8 below level 15", status_o[7], 0);
    push(8'h4E, 4'b0000);
    @(negedge clk_i);
    chk("R8 at level 15", status_o[7], 1);
    chk("R5 no error clean pushes", status_o[10], 0);
    push(8'h4F, 4'b0000);
    push(8'hFF, 4'b0000);
    chk("R5 drop sets error", status_o[10], 1);
    for (int i = 0; i < 15; i++) pop();
    chk("R4 newest entry data", rx_data_o, 8'h4F);
    chk("R4 overrun tag on newest", status_o[11], 1);
    pop();
    chk("R4 drop not stored", status_o[14], 1);
    wr(32'h0);
  endtask

  task automatic t_trig_zero();
    rx_trig_i = 0;
    push(8'h01, 4'b0000);
    @(negedge clk_i);
    chk("R8 level 0 acts as 1", status_o[7], 1);
    wr(32'h0);
    chk("R9 set wins over clear", status_o[7], 1);
    pop();
    wr(32'h0);
    chk("R8 cleared when empty", status_o[7], 0);
    rx_trig_i = 15;
  endtask

  task automatic t_tx_req();
    tx_trig_i = 4; tx_free_i = 3;
    @(negedge clk_i);
    chk("R7 below level", status_o[8], 0);
    tx_free_i = 4;
    @(negedge clk_i);
    chk("R7 at level", status_o[8], 1);
    tx_free_i = 0; tx_trig_i = 0;
    wr(32'h0);
    chk("R7 cleared", status_o[8], 0);
    tx_free_i = 1;
    @(negedge clk_i);
    chk("R7 level 0 acts as 1", status_o[8], 1);
    tx_free_i = 0; tx_trig_i = 15;
    wr(32'h0);
  endtask

  task automatic t_irq();
    @(negedge clk_i); timeout_i = 1;
    @(negedge clk_i); timeout_i = 0;
    irq_en_i = 4'b1011;
    #1 chk("R10 masked", irq_o, 0);
    irq_en_i = 4'b0100;
    #1 chk("R10 enabled", irq_o, 1);
    wr(32'h0);
    chk("R10 drops after clear", irq_o, 0);
    irq_en_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_w0c();
    t_tags();
    t_overflow();
    t_trig_zero();
    t_tx_req();
    t_irq();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule